// File: doc/BRIEF.md
# Module Clock Enable Sequencer

This block switches a peripheral module's functional clock on and off in hardware. A requester asks for one of two actions, turn-on or turn-off, and receives a single-cycle completion pulse. The pulse carries either an error indication or a timeout flag. The sequencer owns the module's clock-control register through a simple read/write port. A read-modify-write loads or clears the two-bit module-mode field and leaves every other bit as it was. The sequencer then polls the two-bit idle-status field until the module reports the wanted state, or until a timeout measured in microsecond ticks runs out.

The two directions run in opposite orders. Turning a module on first raises a request to the clock-domain controller and waits for its acknowledge. Only then does the sequencer write the register and wait for the module to become functional; a timeout here is a hard error. Turning a module off writes the register first and waits for the module to report disabled. It then drops the domain request. A timeout here only raises a flag, and the domain is still released. Two configuration inputs adjust the sequence. One chooses hardware- or software-supervised mode; with no valid mode, the register is not touched and only the domain handshake happens. The other skips status polling. The register's standby bit is passed straight to an output.

Top module: `clk_enable_seq`

## Requirements
- R1: After reset, busy, done, dom_req and reg_wr_en are low. Busy rises on the cycle after an accepted request and stays high through the done cycle. A request that arrives while busy is ignored: it produces no done pulse and no change of dom_req.
- R2: On turn-on, dom_req rises first. A register write that loads a non-zero mode happens only while dom_ack is high.
- R3: Each register write is a read-modify-write. Bits [1:0] become 1 for hardware-supervised mode (cfg_mode=1) or 2 for software-supervised mode (cfg_mode=2) on turn-on, and 0 on turn-off. All other bits are copied unchanged from reg_rdata.
- R4: A turn-on completes without error when the status field reg_rdata[17:16] reads 0 (functional) or 2 (interface idle).
- R5: If the turn-on status is not reached within EN_LIMIT ticks, done is raised with err high.
- R6: A turn-off completes when the status field reads 3 (disabled). dom_req falls after the status wait and before done.
- R7: If the turn-off status is not reached within DIS_LIMIT ticks, done is raised with dis_timeout high and err low, and dom_req is still released.
- R8: With cfg_no_status high, the sequence skips status polling and moves on directly after the register write.
- R9: With cfg_mode 0 or 3, no register write takes place and only the domain handshake is performed.
- R10: The standby output equals reg_rdata bit 18 at all times.
- R11: The timeout counter is cleared at the start of each wait and advances only on us_tick. Without ticks, a wait never times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_on | input | 1 | 1 = turn module on, 0 = turn module off |
| cfg_mode | input | 2 | 1 hardware-supervised, 2 software-supervised, else none |
| cfg_no_status | input | 1 | Skip idle-status polling |
| us_tick | input | 1 | One-microsecond tick |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Turn-on timeout, valid with done |
| dis_timeout | output | 1 | Turn-off timeout flag, valid with done |
| reg_rdata | input | DATA_W | Current clock-control register value |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wdata | output | DATA_W | Register write value |
| dom_req | output | 1 | Clock-domain request level |
| dom_ack | input | 1 | Clock-domain acknowledge |
| standby | output | 1 | Standby indicator from the register |

## Verification
The bench builds the block with EN_LIMIT=6 and DIS_LIMIT=10, and with a tick every fourth clock. Both timeout paths, turn-on error and turn-off flag, therefore complete within a few dozen cycles next to the matching successful paths. The small limits also allow a check that the tick count at a timeout is at least the limit. Stalling the tick for a hundred cycles then shows that no timeout occurs while the tick is absent.

// File: rtl/clkseq_pkg.sv
// Shared definitions for the module clock enable sequencer.
// Assumes the control register is at least 19 bits wide.
package clkseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DOM_UP,
        ST_WRITE,
        ST_WAIT,
        ST_RELEASE,
        ST_FINISH
    } seq_state_t;

    localparam int MODE_LSB = 0;
    localparam int STAT_LSB = 16;
    localparam int STBY_BIT = 18;

    localparam logic [1:0] MODE_OFF = 2'd0;
    localparam logic [1:0] MODE_HW  = 2'd1;
    localparam logic [1:0] MODE_SW  = 2'd2;

    localparam logic [1:0] IDS_FUNC     = 2'd0;
    localparam logic [1:0] IDS_IF_IDLE  = 2'd2;
    localparam logic [1:0] IDS_DISABLED = 2'd3;
endpackage

// File: rtl/clkseq_timer.sv
// Timeout counter for the status wait.
// Cleared by 'clear'. Advances on 'tick' while 'run' is high and
// saturates at 'limit'. 'expired' is high once the count reaches the limit.
module clkseq_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    assign expired = (cnt >= limit);

    // Count microsecond ticks during a wait phase
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (run && tick && !expired)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/clkseq_fsm.sv
// Sequencer state machine.
// Turn-on order: domain request, acknowledge, register write, wait for functional.
// Turn-off order: register write, wait for disabled, domain release.
// Assumes reg_rdata reflects a write on the cycle after it.
module clkseq_fsm
    import clkseq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_on,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_no_status,
    input  logic              dom_ack,
    input  logic [DATA_W-1:0] ctrl_rd,
    input  logic              tmr_expired,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              dis_timeout,
    output logic              dom_req,
    output logic              ctrl_we,
    output logic [DATA_W-1:0] ctrl_wd,
    output logic              tmr_clear,
    output logic              tmr_run,
    output logic              tmr_on_dir
);
    seq_state_t state;
    logic       dir_q;
    logic [1:0] mode_q;
    logic       nost_q;
    logic       err_q;
    logic       dto_q;
    logic       dom_req_q;

    logic       mode_ok;
    logic [1:0] stat;
    logic       stat_match;

    assign mode_ok    = (cfg_mode == MODE_HW) || (cfg_mode == MODE_SW);
    assign stat       = ctrl_rd[STAT_LSB +: 2];
    assign stat_match = dir_q ? (stat == IDS_FUNC || stat == IDS_IF_IDLE)
                              : (stat == IDS_DISABLED);

    // Sequence progression and latched request context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            dir_q     <= 1'b0;
            mode_q    <= MODE_OFF;
            nost_q    <= 1'b0;
            err_q     <= 1'b0;
            dto_q     <= 1'b0;
            dom_req_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    dir_q  <= req_on;
                    mode_q <= mode_ok ? cfg_mode : MODE_OFF;
                    nost_q <= cfg_no_status;
                    err_q  <= 1'b0;
                    dto_q  <= 1'b0;
                    if (req_on) begin
                        dom_req_q <= 1'b1;
                        state     <= ST_DOM_UP;
                    end else begin
                        state <= mode_ok ? ST_WRITE : ST_RELEASE;
                    end
                end
                ST_DOM_UP: if (dom_ack)
                    state <= (mode_q != MODE_OFF) ? ST_WRITE : ST_FINISH;
                ST_WRITE:
                    state <= !nost_q ? ST_WAIT : (dir_q ? ST_FINISH : ST_RELEASE);
                ST_WAIT: begin
                    if (stat_match) begin
                        state <= dir_q ? ST_FINISH : ST_RELEASE;
                    end else if (tmr_expired) begin
                        if (dir_q) begin
                            err_q <= 1'b1;
                            state <= ST_FINISH;
                        end else begin
                            dto_q <= 1'b1;
                            state <= ST_RELEASE;
                        end
                    end
                end
                ST_RELEASE: begin
                    dom_req_q <= 1'b0;
                    state     <= ST_FINISH;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the state register
    always_comb begin
        busy        = (state != ST_IDLE);
        done        = (state == ST_FINISH);
        err         = done && err_q;
        dis_timeout = done && dto_q;
        dom_req     = dom_req_q;
        ctrl_we     = (state == ST_WRITE);
        ctrl_wd     = {ctrl_rd[DATA_W-1:2], (dir_q ? mode_q : MODE_OFF)};
        tmr_clear   = (state == ST_WRITE);
        tmr_run     = (state == ST_WAIT);
        tmr_on_dir  = dir_q;
    end
endmodule

// File: rtl/clk_enable_seq.sv
// Top of the module clock enable sequencer.
// Joins the state machine and the timeout counter and picks the
// limit for the current direction. The standby bit is passed straight through.
module clk_enable_seq
    import clkseq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int EN_LIMIT  = 2000,
    parameter int DIS_LIMIT = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_on,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_no_status,
    input  logic              us_tick,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              dis_timeout,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              dom_req,
    input  logic              dom_ack,
    output logic              standby
);
    localparam int MAX_LIMIT = (EN_LIMIT > DIS_LIMIT) ? EN_LIMIT : DIS_LIMIT;
    localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

    logic             tmr_clear;
    logic             tmr_run;
    logic             tmr_on_dir;
    logic             tmr_expired;
    logic [CNT_W-1:0] tmr_limit;

    assign tmr_limit = tmr_on_dir ? CNT_W'(EN_LIMIT) : CNT_W'(DIS_LIMIT);
    assign standby   = reg_rdata[STBY_BIT];

    clkseq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_on       (req_on),
        .cfg_mode     (cfg_mode),
        .cfg_no_status(cfg_no_status),
        .dom_ack      (dom_ack),
        .ctrl_rd      (reg_rdata),
        .tmr_expired  (tmr_expired),
        .busy         (busy),
        .done         (done),
        .err          (err),
        .dis_timeout  (dis_timeout),
        .dom_req      (dom_req),
        .ctrl_we      (reg_wr_en),
        .ctrl_wd      (reg_wdata),
        .tmr_clear    (tmr_clear),
        .tmr_run      (tmr_run),
        .tmr_on_dir   (tmr_on_dir)
    );

    clkseq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .run    (tmr_run),
        .tick   (us_tick),
        .limit  (tmr_limit),
        .expired(tmr_expired)
    );
endmodule

// File: rtl/clkseq_chk.sv
// Property checker for clk_enable_seq, attached through bind.
module clkseq_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              dis_timeout,
    input logic              dom_req,
    input logic              dom_ack,
    input logic              reg_wr_en,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              standby
);
    // R1: completion only inside a busy sequence, and a single pulse
    a_r1_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r1_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: a mode-loading write only once the domain has acknowledged
    a_r2_ack_before_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wdata[1:0] != 2'd0) |-> (dom_req && dom_ack));
    // R3: untouched bits follow the read value
    a_r3_preserve: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (reg_wdata[DATA_W-1:2] == reg_rdata[DATA_W-1:2]));
    // R5 / R7: error and flag only with done, never together
    a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    a_r7_flag_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        dis_timeout |-> (done && !err));
    // R6: domain released inside a sequence, right before done
    a_r6_release_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_req) |-> done);
    // R10: standby follows bit 18
    a_r10_standby: assert property (@(posedge clk) disable iff (!rst_n)
        standby == reg_rdata[18]);
endmodule

bind clk_enable_seq clkseq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .dis_timeout(dis_timeout),
    .dom_req    (dom_req),
    .dom_ack    (dom_ack),
    .reg_wr_en  (reg_wr_en),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .standby    (standby)
);

// File: tb/sim_clk_enable_seq.sv
// Bench for clk_enable_seq. It models the control register and the domain
// controller, walks a vector table, then runs directed corner tests.
module sim_clk_enable_seq;
    localparam int DATA_W    = 32;
    localparam int EN_LIMIT  = 6;
    localparam int DIS_LIMIT = 10;
    localparam logic [31:0] INIT_REG = 32'hA5A0_5A5C;
    localparam logic [31:0] KEEP_MSK = 32'hFFF8_FFFC;

    // Vector: [11]on [10:9]mode [8]nost [7:6]stat [5]err [4]dto [3:2]bits [1]wr [0]dom_req
    localparam logic [11:0] VEC [9] = '{
        {1'b1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1}, // R4 on, hw, functional
        {1'b0, 2'd1, 1'b0, 2'd3, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0}, // R6 off, disabled
        {1'b1, 2'd2, 1'b0, 2'd2, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1}, // R4 on, sw, interface idle
        {1'b1, 2'd2, 1'b0, 2'd3, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1}, // R5 on timeout
        {1'b0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0}, // R7 off timeout
        {1'b1, 2'd1, 1'b1, 2'd3, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1}, // R8 on, no polling
        {1'b0, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0}, // R8 off, no polling
        {1'b1, 2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1}, // R9 on, no mode
        {1'b0, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0}  // R9 off, no mode
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_on = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic cfg_no_status = 1'b0;
    logic us_tick;
    logic busy, done, err, dis_timeout, reg_wr_en, dom_req, dom_ack, standby;
    logic [DATA_W-1:0] reg_rdata, reg_wdata;

    logic [31:0] ctrl;
    logic [1:0]  stat_next = 2'd0;
    logic        stby_bit = 1'b0;
    logic        tick_en = 1'b1;
    logic [1:0]  div;
    int tick_total, wr_total, done_total, order_bad;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    assign reg_rdata = {ctrl[31:19], stby_bit, ctrl[17:0]};

    clk_enable_seq #(.DATA_W(DATA_W), .EN_LIMIT(EN_LIMIT), .DIS_LIMIT(DIS_LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
        .cfg_mode(cfg_mode), .cfg_no_status(cfg_no_status), .us_tick(us_tick),
        .busy(busy), .done(done), .err(err), .dis_timeout(dis_timeout),
        .reg_rdata(reg_rdata), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .dom_req(dom_req), .dom_ack(dom_ack), .standby(standby)
    );

    // Register model, domain model, tick source and event counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= INIT_REG;
            dom_ack <= 1'b0;
            div <= 2'd0;
            us_tick <= 1'b0;
            tick_total <= 0;
            wr_total <= 0;
            done_total <= 0;
            order_bad <= 0;
        end else begin
            dom_ack <= dom_req;
            div <= div + 2'd1;
            us_tick <= tick_en && (div == 2'd3);
            if (us_tick && busy) tick_total <= tick_total + 1;
            if (done) done_total <= done_total + 1;
            if (reg_wr_en) begin
                ctrl <= {reg_wdata[31:19], 1'b0, stat_next, reg_wdata[15:0]};
                wr_total <= wr_total + 1;
                if (reg_wdata[1:0] != 2'd0 && !dom_ack) order_bad <= order_bad + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one request; optionally inject a second request while busy
    task automatic run_req(input bit on, input logic [1:0] mode, input bit nost,
                           input logic [1:0] stat, input bit inject,
                           output bit e, output bit d);
        @(negedge clk);
        stat_next = stat;
        req_valid = 1'b1; req_on = on; cfg_mode = mode; cfg_no_status = nost;
        @(negedge clk);
        req_valid = 1'b0;
        e = 1'b0; d = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (inject && i == 3) begin req_valid = 1'b1; req_on = ~on; end
            else req_valid = 1'b0;
            if (done) begin e = err; d = dis_timeout; break; end
            @(negedge clk);
        end
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        bit e, d;
        int t0, w0, d0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !dom_req && !reg_wr_en, "R1 reset",
            {busy, done, dom_req, reg_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 9; v++) begin
            logic [11:0] x;
            x = VEC[v];
            t0 = tick_total; w0 = wr_total;
            run_req(x[11], x[10:9], x[8], x[7:6], 1'b0, e, d);
            chk(!busy, x[8] ? "R8 complete" : (x[11] ? "R4 complete" : "R6 complete"),
                busy, 0);
            chk(e == x[5], "R5 err", e, x[5]);
            chk(d == x[4], "R7 flag", d, x[4]);
            chk(ctrl[1:0] == x[3:2], "R3 mode bits", ctrl[1:0], x[3:2]);
            chk((ctrl & KEEP_MSK) == (INIT_REG & KEEP_MSK), "R3 preserved",
                ctrl & KEEP_MSK, INIT_REG & KEEP_MSK);
            chk((wr_total - w0) == int'(x[1]), "R9 write count", wr_total - w0, x[1]);
            chk(dom_req == x[0], "R6 dom_req level", dom_req, x[0]);
            if (x[5]) chk(tick_total - t0 >= EN_LIMIT, "R5 ticks", tick_total - t0, EN_LIMIT);
            if (x[4]) chk(tick_total - t0 >= DIS_LIMIT, "R7 ticks", tick_total - t0, DIS_LIMIT);
        end
        chk(order_bad == 0, "R2 write after ack", order_bad, 0);

        // R1: request arriving while busy is ignored (domain is up from the last on)
        run_req(1'b0, 2'd1, 1'b0, 2'd3, 1'b0, e, d);
        d0 = done_total;
        run_req(1'b1, 2'd2, 1'b0, 2'd3, 1'b1, e, d);
        repeat (6) @(negedge clk);
        chk(done_total - d0 == 1, "R1 ignored done", done_total - d0, 1);
        chk(!busy && dom_req, "R1 ignored state", {busy, dom_req}, 1);

        // R11: no ticks, no timeout
        run_req(1'b0, 2'd1, 1'b0, 2'd3, 1'b0, e, d);
        tick_en = 1'b0;
        @(negedge clk);
        stat_next = 2'd3;
        req_valid = 1'b1; req_on = 1'b1; cfg_mode = 2'd1; cfg_no_status = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (100) @(negedge clk);
        chk(busy && !done, "R11 stalled wait", {busy, done}, 2);
        tick_en = 1'b1;
        e = 1'b0;
        for (int i = 0; i < 500; i++) begin
            if (done) begin e = err; break; end
            @(negedge clk);
        end
        chk(e, "R11 timeout after ticks", e, 1);

        // R10: standby passthrough
        stby_bit = 1'b1; #1;
        chk(standby == 1'b1, "R10 standby high", standby, 1);
        stby_bit = 1'b0; #1;
        chk(standby == 1'b0, "R10 standby low", standby, 0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule